// File: doc/BRIEF.md
# Three-Bank Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, organised as three banks of 32, and turns them into two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has two configuration fields. The first is a 6-bit priority, where 0 is the most urgent. The second is a class bit that routes the line to the fast output. Each bank also has a mask, a software-interrupt vector and a pending vector.

When a class has an unmasked pending line, the controller picks a winner by priority and latches the winner's line number as the active code for that class. It then raises the request output. The output stays high, and the code stays frozen, until software writes the matching acknowledge bit in the control register. That write re-arms the class for the next delivery.

Software reaches the block through a single-cycle register port with a 12-bit byte address space. Writes take effect on the clock edge that samples them. Read data, and an error flag for accesses to a nonexistent bank, come back on the following cycle. A global mask bit can block all new deliveries. Writing a bit in the system configuration register performs a soft reset, which returns every piece of state to its reset value.

Top module: `lvl_intc`

## Requirements
- R1: After reset, all three bank masks read 0xFFFFFFFF, and the pending, software and configuration state reads 0. Both request outputs are low, both active codes read 0, the revision register (0x000) reads 0x21, and the status register (0x014) reads 1.
- R2: The raw input vector of bank b reads at 0x080+0x20*b. When a line rises, its pending bit is set on the same clock edge that captures it into the raw vector.
- R3: When any raw input of a bank falls, that bank's pending vector becomes its current raw inputs ORed with its software vector.
- R4: Mask registers: a write to 0x084+0x20*b replaces the mask, a write to 0x088+0x20*b clears the bits that are 1 in the data, and a write to 0x08C+0x20*b sets them. The clear and set addresses read as 0.
- R5: A write to 0x090+0x20*b ORs the data into both the software vector and the pending vector, and a read of that address returns the software vector. A write to 0x094+0x20*b clears the given bits of the software vector and then sets pending to the new software vector ANDed with the raw inputs.
- R6: The normal-pending view at 0x098+0x20*b reads pending & ~mask & ~class. The fast-pending view at 0x09C+0x20*b reads pending & ~mask & class.
- R7: The configuration word of line n in bank b sits at 0x100+0x80*b+4*n. Bits [7:2] hold the priority and bit 0 holds the class (1 = fast). A read returns the word in the same layout, with all other bits 0.
- R8: A class is delivered when it is armed, has at least one eligible line and the global mask is clear. Its output then rises on the edge after the pending state becomes visible. The code is the eligible line with the smallest priority value, and a tie goes to the highest line number (0..95). Codes read at 0x040 (normal) and 0x044 (fast), and reading them has no side effect.
- R9: A delivered output and its code hold until the control register (0x048) is written with bit 0 (normal) or bit 1 (fast) set. That write drops the output on its edge and re-arms the class, so an eligible line is delivered again on the next edge.
- R10: Bit 2 of the control register is the global mask. While it is 1, no new delivery starts. It reads back at bit 2 of 0x048.
- R11: At 0x010, bit 0 (automatic idle) reads back. The idle register at 0x050 holds two bits. Writing 0x010 with bit 1 set returns all state to the R1 values on that edge.
- R12: Writes to 0x000, 0x014, 0x040, 0x044 and the raw and pending views are ignored. The protection register at 0x04C accepts writes and reads 0.
- R13: Accesses to bank index 3 are rejected: per-bank addresses with bits [6:5] = 3 (0x0E0–0x0FF), and configuration words 0x280–0x2FF. A rejected write changes nothing, a rejected read returns 0, and `err_o` is 1 on the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 96 | Level interrupt lines; line 32*b+n is line n of bank b |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| err_o | output | 1 | Rejected-access flag, valid the cycle after an access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
- **Line inputs.** A line change is captured into the raw and pending vectors on the first edge after it. The request output follows one edge later. The bench therefore drives lines at a falling edge and samples `irq_o`/`fiq_o` at the falling edge after the second rising edge, after checking that the output is still low after the first.
- **Register writes.** A write acts on the edge that samples it. An acknowledge therefore shows as a low output at the very next falling edge, and a re-delivery shows one cycle after that.
- **Register reads.** Read data and `err_o` are registered. Each read task samples them at the falling edge that follows the sampling edge, which keeps every result away from the active clock edge.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    localparam int LINES  = 32;
    localparam int PRIO_W = 6;
    localparam int DW     = 32;
    localparam int LW     = $clog2(LINES);
    localparam logic [7:0] REV_ID = 8'h21;

    typedef enum logic [2:0] {
        BOP_NONE,
        BOP_MASK,
        BOP_MCLR,
        BOP_MSET,
        BOP_SSET,
        BOP_SCLR
    } bank_op_e;

    typedef struct packed {
        logic [LINES-1:0]             raw;
        logic [LINES-1:0]             mask;
        logic [LINES-1:0]             swi;
        logic [LINES-1:0]             pend;
        logic [LINES-1:0]             fsel;
        logic [LINES-1:0][PRIO_W-1:0] prio;
    } bank_st_t;

    localparam bank_st_t BANK_RST = '{
        raw:  '0,
        mask: '1,
        swi:  '0,
        pend: '0,
        fsel: '0,
        prio: '0
    };

endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank
    import lvl_intc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic [LINES-1:0]         lines_i,
    input  bank_op_e                 op_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic                     cfg_we_i,
    input  logic [LW-1:0]            cfg_line_i,
    output logic [LINES-1:0]         raw_o,
    output logic [LINES-1:0]         mask_o,
    output logic [LINES-1:0]         swi_o,
    output logic [LINES-1:0]         pend_o,
    output logic [LINES-1:0]         fsel_o,
    output logic [LINES*PRIO_W-1:0]  prio_o
);

    bank_st_t st_d, st_q;
    logic [LINES-1:0] rise, fall;

    always_comb begin
        st_d = st_q;
        rise = lines_i & ~st_q.raw;
        fall = ~lines_i & st_q.raw;
        if (soft_rst) begin
            st_d = BANK_RST;
        end else begin
            case (op_i)
                BOP_MASK: st_d.mask = wdata_i;
                BOP_MCLR: st_d.mask = st_q.mask & ~wdata_i;
                BOP_MSET: st_d.mask = st_q.mask | wdata_i;
                BOP_SSET: begin
                    st_d.swi  = st_q.swi | wdata_i;
                    st_d.pend = st_q.pend | wdata_i;
                end
                BOP_SCLR: begin
                    st_d.swi  = st_q.swi & ~wdata_i;
                    st_d.pend = st_d.swi & st_q.raw;
                end
                default: ;
            endcase
            if (cfg_we_i) begin
                st_d.prio[cfg_line_i] = wdata_i[PRIO_W+1:2];
                st_d.fsel[cfg_line_i] = wdata_i[0];
            end
            // a falling line rebuilds pending from live inputs and software bits
            if (|fall) begin
                st_d.pend = lines_i | st_d.swi;
            end else begin
                st_d.pend = st_d.pend | rise;
            end
            st_d.raw = lines_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BANK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign swi_o  = st_q.swi;
    assign pend_o = st_q.pend;
    assign fsel_o = st_q.fsel;
    assign prio_o = st_q.prio;

endmodule

// File: rtl/lvl_intc_arb.sv
module lvl_intc_arb #(
    parameter int N  = 96,
    parameter int PW = 6,
    parameter int CW = 7
) (
    input  logic [N-1:0]    elig_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            hit_o,
    output logic [CW-1:0]   code_o
);

    logic [PW-1:0] best;

    // ascending scan with <= : smallest value wins, ties go to the higher line
    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        best   = '1;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (prio_i[i*PW +: PW] <= best)) begin
                best   = prio_i[i*PW +: PW];
                code_o = CW'(i);
                hit_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int AW    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBANK*32-1:0]    irq_lines_i,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [31:0]            wdata_i,
    output logic [31:0]            rdata_o,
    output logic                   err_o,
    output logic                   irq_o,
    output logic                   fiq_o
);

    localparam int NLINE = NBANK * LINES;
    localparam int CW    = $clog2(NLINE);
    localparam int NCLS  = 2;

    localparam logic [AW-1:0] A_REV  = AW'('h000);
    localparam logic [AW-1:0] A_SCFG = AW'('h010);
    localparam logic [AW-1:0] A_STAT = AW'('h014);
    localparam logic [AW-1:0] A_CIRQ = AW'('h040);
    localparam logic [AW-1:0] A_CFIQ = AW'('h044);
    localparam logic [AW-1:0] A_CTRL = AW'('h048);
    localparam logic [AW-1:0] A_IDLE = AW'('h050);

    typedef struct packed {
        logic            gmask;
        logic            autoidle;
        logic [1:0]      idle;
        logic [NCLS-1:0] agr;
        logic [NCLS-1:0] out;
        logic [CW-1:0]   code_irq;
        logic [CW-1:0]   code_fiq;
        logic [31:0]     rdata;
        logic            err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        gmask: 1'b0, autoidle: 1'b0, idle: 2'b00, agr: 2'b11, out: 2'b00,
        code_irq: '0, code_fiq: '0, rdata: '0, err: 1'b0
    };

    ctl_t ctl_d, ctl_q;

    // bank state
    logic [LINES-1:0]        b_raw  [NBANK];
    logic [LINES-1:0]        b_mask [NBANK];
    logic [LINES-1:0]        b_swi  [NBANK];
    logic [LINES-1:0]        b_pend [NBANK];
    logic [LINES-1:0]        b_fsel [NBANK];
    logic [LINES*PRIO_W-1:0] b_prio [NBANK];
    bank_op_e                b_op   [NBANK];
    logic                    b_cfg  [NBANK];

    logic [NCLS-1:0][NLINE-1:0] elig;
    logic [NLINE*PRIO_W-1:0]    prio_all;
    logic [NCLS-1:0]            hit;
    logic [CW-1:0]              win [NCLS];

    // decode
    logic          wr, rd, soft_rst, gmask_q;
    logic          in_bank, in_cfg, bank_ok, cfg_ok, bad, in_glob;
    logic [1:0]    bsel, csel;
    logic [2:0]    boff, cdiff;
    logic [LW-1:0] cline;
    logic [NCLS-1:0] ack;

    assign wr       = req_i & we_i;
    assign rd       = req_i & ~we_i;
    assign in_bank  = addr_i[AW-1:7] == (AW-7)'(1);
    assign bsel     = addr_i[6:5];
    assign boff     = addr_i[4:2];
    assign in_cfg   = (addr_i[AW-1:8] == (AW-8)'(1)) || (addr_i[AW-1:8] == (AW-8)'(2));
    assign cdiff    = addr_i[9:7] - 3'd2;
    assign csel     = cdiff[1:0];
    assign cline    = addr_i[LW+1:2];
    assign bank_ok  = in_bank && (32'(bsel) < NBANK);
    assign cfg_ok   = in_cfg && (32'(csel) < NBANK);
    assign bad      = (in_bank && !bank_ok) || (in_cfg && !cfg_ok);
    assign in_glob  = addr_i[AW-1:7] == '0;
    assign soft_rst = wr && (addr_i == A_SCFG) && wdata_i[1];
    assign ack[0]   = wr && (addr_i == A_CTRL) && wdata_i[0];
    assign ack[1]   = wr && (addr_i == A_CTRL) && wdata_i[1];
    assign gmask_q  = ctl_q.gmask;

    // per-bank operation strobes
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            b_op[b]  = BOP_NONE;
            b_cfg[b] = 1'b0;
            if (wr && bank_ok && (bsel == 2'(b))) begin
                case (boff)
                    3'd1:    b_op[b] = BOP_MASK;
                    3'd2:    b_op[b] = BOP_MCLR;
                    3'd3:    b_op[b] = BOP_MSET;
                    3'd4:    b_op[b] = BOP_SSET;
                    3'd5:    b_op[b] = BOP_SCLR;
                    default: b_op[b] = BOP_NONE;
                endcase
            end
            if (wr && cfg_ok && (csel == 2'(b))) begin
                b_cfg[b] = 1'b1;
            end
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank
            lvl_intc_bank u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .soft_rst   (soft_rst),
                .lines_i    (irq_lines_i[gb*LINES +: LINES]),
                .op_i       (b_op[gb]),
                .wdata_i    (wdata_i),
                .cfg_we_i   (b_cfg[gb]),
                .cfg_line_i (cline),
                .raw_o      (b_raw[gb]),
                .mask_o     (b_mask[gb]),
                .swi_o      (b_swi[gb]),
                .pend_o     (b_pend[gb]),
                .fsel_o     (b_fsel[gb]),
                .prio_o     (b_prio[gb])
            );
            assign elig[0][gb*LINES +: LINES] = b_pend[gb] & ~b_mask[gb] & ~b_fsel[gb];
            assign elig[1][gb*LINES +: LINES] = b_pend[gb] & ~b_mask[gb] &  b_fsel[gb];
            assign prio_all[gb*LINES*PRIO_W +: LINES*PRIO_W] = b_prio[gb];
        end
    endgenerate

    genvar gc;
    generate
        for (gc = 0; gc < NCLS; gc++) begin : g_cls
            lvl_intc_arb #(.N(NLINE), .PW(PRIO_W), .CW(CW)) u_arb (
                .elig_i (elig[gc]),
                .prio_i (prio_all),
                .hit_o  (hit[gc]),
                .code_o (win[gc])
            );
        end
    endgenerate

    // read mux
    logic [31:0] rv;
    always_comb begin
        rv = '0;
        if (bank_ok) begin
            for (int b = 0; b < NBANK; b++) begin
                if (bsel == 2'(b)) begin
                    case (boff)
                        3'd0:    rv = b_raw[b];
                        3'd1:    rv = b_mask[b];
                        3'd4:    rv = b_swi[b];
                        3'd6:    rv = b_pend[b] & ~b_mask[b] & ~b_fsel[b];
                        3'd7:    rv = b_pend[b] & ~b_mask[b] &  b_fsel[b];
                        default: rv = '0;
                    endcase
                end
            end
        end else if (cfg_ok) begin
            for (int b = 0; b < NBANK; b++) begin
                if (csel == 2'(b)) begin
                    rv[PRIO_W+1:2] = b_prio[b][cline*PRIO_W +: PRIO_W];
                    rv[0]          = b_fsel[b][cline];
                end
            end
        end else if (in_glob) begin
            case (addr_i)
                A_REV:   rv = 32'(REV_ID);
                A_SCFG:  rv = 32'(ctl_q.autoidle);
                A_STAT:  rv = 32'd1;
                A_CIRQ:  rv = 32'(ctl_q.code_irq);
                A_CFIQ:  rv = 32'(ctl_q.code_fiq);
                A_CTRL:  rv = {29'd0, ctl_q.gmask, 2'b00};
                A_IDLE:  rv = 32'(ctl_q.idle);
                default: rv = '0;
            endcase
        end
    end

    // control next state
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.err   = req_i && bad;
        ctl_d.rdata = (rd && !bad) ? rv : '0;
        if (wr && addr_i == A_SCFG) ctl_d.autoidle = wdata_i[0];
        if (wr && addr_i == A_IDLE) ctl_d.idle     = wdata_i[1:0];
        if (wr && addr_i == A_CTRL) ctl_d.gmask    = wdata_i[2];

        if (ack[0]) begin
            ctl_d.out[0] = 1'b0;
            ctl_d.agr[0] = 1'b1;
        end else if (ctl_q.agr[0] && hit[0] && !ctl_q.gmask) begin
            ctl_d.out[0]   = 1'b1;
            ctl_d.agr[0]   = 1'b0;
            ctl_d.code_irq = win[0];
        end

        if (ack[1]) begin
            ctl_d.out[1] = 1'b0;
            ctl_d.agr[1] = 1'b1;
        end else if (ctl_q.agr[1] && hit[1] && !ctl_q.gmask) begin
            ctl_d.out[1]   = 1'b1;
            ctl_d.agr[1]   = 1'b0;
            ctl_d.code_fiq = win[1];
        end

        if (soft_rst) ctl_d = CTL_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata_o = ctl_q.rdata;
    assign err_o   = ctl_q.err;
    assign irq_o   = ctl_q.out[0];
    assign fiq_o   = ctl_q.out[1];

endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_o,
    input logic fiq_o,
    input logic soft_rst,
    input logic ack_irq,
    input logic ack_fiq,
    input logic gmask,
    input logic hit_irq,
    input logic hit_fiq,
    input logic req,
    input logic err
);

    // R9
    irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_irq && !soft_rst) |=> irq_o);

    // R9
    fiq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o && !ack_fiq && !soft_rst) |=> fiq_o);

    // R10
    gmask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) || $rose(fiq_o)) |-> $past(!gmask));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(hit_irq));

    // R8
    fiq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> $past(hit_fiq));

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq_o && !fiq_o));

    // R13
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req));

endmodule

bind lvl_intc lvl_intc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .soft_rst (soft_rst),
    .ack_irq  (ack[0]),
    .ack_fiq  (ack[1]),
    .gmask    (gmask_q),
    .hit_irq  (hit[0]),
    .hit_fiq  (hit[1]),
    .req      (req_i),
    .err      (err_o)
);

// File: tb/tb_lvl_intc.sv
`timescale 1ns/1ps
module tb_lvl_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] lines = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        irq, fiq;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] rd_val;
    logic        rd_err;
    logic        wr_err;

    always #2.5 clk = ~clk;

    lvl_intc dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_lines_i (lines),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .err_o       (err),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        wr_err = err;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        rd_val = rdata;
        rd_err = err;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic t_reset();
        chk("R1 irq low", 32'(irq), 0);
        chk("R1 fiq low", 32'(fiq), 0);
        rd(12'h000); chk("R1 revision", rd_val, 32'h21);
        rd(12'h014); chk("R1 status", rd_val, 1);
        for (int b = 0; b < 3; b++) begin
            rd(12'(12'h084 + 32 * b)); chk("R1 mask", rd_val, 32'hFFFF_FFFF);
        end
        rd(12'h040); chk("R1 irq code", rd_val, 0);
        rd(12'h098); chk("R1 pending", rd_val, 0);
        rd(12'h048); chk("R1 control", rd_val, 0);
    endtask

    task automatic t_capture();
        wr(12'h084, 32'hFFFF_FFDF);
        lines[5] = 1'b1;
        wait_cyc(1); chk("R2 irq not yet", 32'(irq), 0);
        wait_cyc(1); chk("R8 irq raised", 32'(irq), 1);
        rd(12'h080); chk("R2 raw", rd_val, 32'h20);
        rd(12'h098); chk("R6 pend irq", rd_val, 32'h20);
        rd(12'h040); chk("R8 code", rd_val, 5);
        rd(12'h040); chk("R8 code no side effect", rd_val, 5);
    endtask

    task automatic t_ack();
        lines[5] = 1'b0;
        wait_cyc(3); chk("R9 held", 32'(irq), 1);
        rd(12'h098); chk("R3 pend after fall", rd_val, 0);
        wr(12'h048, 1); chk("R9 dropped", 32'(irq), 0);
        wait_cyc(2); chk("R9 no redelivery", 32'(irq), 0);
    endtask

    task automatic t_priority();
        wr(12'h124, 32'h50);   // bank0 line9 prio 20
        wr(12'h18C, 32'h28);   // bank1 line3 prio 10
        wr(12'h21C, 32'h28);   // bank2 line7 prio 10
        wr(12'h088, 32'hFFFF_FFFF);
        wr(12'h0A8, 32'hFFFF_FFFF);
        wr(12'h0C8, 32'hFFFF_FFFF);
        lines[9] = 1'b1; lines[35] = 1'b1; lines[71] = 1'b1;
        wait_cyc(2); chk("R8 irq", 32'(irq), 1);
        rd(12'h040); chk("R8 tie to highest line", rd_val, 71);
        rd(12'h21C); chk("R7 config readback", rd_val, 32'h28);
        wr(12'h21C, 32'h78);   // prio 30
        wr(12'h048, 1); chk("R9 ack drop", 32'(irq), 0);
        wait_cyc(1); chk("R9 redelivered", 32'(irq), 1);
        rd(12'h040); chk("R8 lowest value wins", rd_val, 35);
        lines[9] = 1'b0; lines[35] = 1'b0; lines[71] = 1'b0;
        wr(12'h048, 1);
        wait_cyc(2); chk("R9 idle after ack", 32'(irq), 0);
    endtask

    task automatic t_fast();
        wr(12'h108, 32'h1);    // bank0 line2 fast, prio 0
        lines[2] = 1'b1;
        wait_cyc(2);
        chk("R8 fiq raised", 32'(fiq), 1);
        chk("R8 irq stays low", 32'(irq), 0);
        rd(12'h044); chk("R8 fiq code", rd_val, 2);
        rd(12'h09C); chk("R6 pend fiq view", rd_val, 32'h4);
        rd(12'h098); chk("R6 pend irq view", rd_val, 0);
        lines[2] = 1'b0;
        wr(12'h048, 2); chk("R9 fiq ack", 32'(fiq), 0);
        wait_cyc(2); chk("R9 fiq stays low", 32'(fiq), 0);
    endtask

    task automatic t_soft();
        wr(12'h0B0, 32'h10);
        wait_cyc(1); chk("R5 soft irq", 32'(irq), 1);
        rd(12'h0B0); chk("R5 soft vector", rd_val, 32'h10);
        rd(12'h040); chk("R5 soft code", rd_val, 36);
        wr(12'h0B4, 32'h10);
        rd(12'h0B8); chk("R5 soft clear pend", rd_val, 0);
        wr(12'h048, 1);
        lines[33] = 1'b1;
        wait_cyc(2);
        wr(12'h0B0, 32'h1);
        lines[33] = 1'b0;
        wait_cyc(2);
        rd(12'h0B8); chk("R3 pend = raw|soft", rd_val, 32'h1);
        rd(12'h0A0); chk("R2 raw bank1", rd_val, 0);
        wr(12'h0B4, 32'h1);
        rd(12'h0B8); chk("R5 clear leaves none", rd_val, 0);
        wr(12'h048, 1);
        wait_cyc(2); chk("R9 cleared", 32'(irq), 0);
    endtask

    task automatic t_mask();
        wr(12'h084, 32'h0000_FF00);
        wr(12'h08C, 32'h1);
        wr(12'h088, 32'h100);
        rd(12'h084); chk("R4 mask set/clear", rd_val, 32'h0000_FE01);
        rd(12'h088); chk("R4 clear reads 0", rd_val, 0);
        rd(12'h08C); chk("R4 set reads 0", rd_val, 0);
    endtask

    task automatic t_gmask();
        wr(12'h084, 32'h0);
        wr(12'h048, 32'h4);
        rd(12'h048); chk("R10 gmask readback", rd_val, 32'h4);
        lines[1] = 1'b1;
        wait_cyc(4); chk("R10 blocked", 32'(irq), 0);
        wr(12'h048, 32'h0);
        wait_cyc(1); chk("R10 delivered after unmask", 32'(irq), 1);
        rd(12'h040); chk("R10 code", rd_val, 1);
    endtask

    task automatic t_regs();
        wr(12'h010, 1); rd(12'h010); chk("R11 autoidle", rd_val, 1);
        wr(12'h050, 3); rd(12'h050); chk("R11 idle", rd_val, 3);
        wr(12'h050, 6); rd(12'h050); chk("R11 idle width", rd_val, 2);
        wr(12'h04C, 1); rd(12'h04C); chk("R12 protection", rd_val, 0);
        wr(12'h000, 32'h55); rd(12'h000); chk("R12 revision ro", rd_val, 32'h21);
        wr(12'h014, 0); rd(12'h014); chk("R12 status ro", rd_val, 1);
        wr(12'h040, 7); rd(12'h040); chk("R12 code ro", rd_val, 1);
        wr(12'h080, 0); rd(12'h080); chk("R12 raw ro", rd_val, 32'h2);
        wr(12'h098, 0); rd(12'h098); chk("R12 pend ro", rd_val, 32'h2);
        wr(12'h010, 2); chk("R11 soft reset irq", 32'(irq), 0);
        rd(12'h084); chk("R11 mask reset", rd_val, 32'hFFFF_FFFF);
        rd(12'h010); chk("R11 autoidle reset", rd_val, 0);
        rd(12'h050); chk("R11 idle reset", rd_val, 0);
        rd(12'h108); chk("R11 config reset", rd_val, 0);
        rd(12'h040); chk("R11 code reset", rd_val, 0);
        lines = '0;
    endtask

    task automatic t_reject();
        wr(12'h0E4, 0); chk("R13 write err", 32'(wr_err), 1);
        rd(12'h0E4); chk("R13 read zero", rd_val, 0); chk("R13 read err", 32'(rd_err), 1);
        rd(12'h2A0); chk("R13 cfg read zero", rd_val, 0); chk("R13 cfg err", 32'(rd_err), 1);
        wr(12'h280, 32'hFD);
        rd(12'h084); chk("R13 bank0 mask", rd_val, 32'hFFFF_FFFF); chk("R13 no err", 32'(rd_err), 0);
        rd(12'h0A4); chk("R13 bank1 mask", rd_val, 32'hFFFF_FFFF);
        rd(12'h0C4); chk("R13 bank2 mask", rd_val, 32'hFFFF_FFFF);
        rd(12'h100); chk("R13 cfg b0", rd_val, 0);
        rd(12'h180); chk("R13 cfg b1", rd_val, 0);
        rd(12'h200); chk("R13 cfg b2", rd_val, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_capture();
        t_ack();
        t_priority();
        t_fast();
        t_soft();
        t_mask();
        t_gmask();
        t_regs();
        t_reject();
        report();
    end

endmodule